// File: doc/BRIEF.md
# External Bus Word Packer

This block sits between an internal memory port and a 32-bit external data bus. For a read, it issues one or more narrow external transfers and joins their data into one internal word. For a write, it cuts an internal word into narrow pieces and presents them one per external transfer. In both directions it also produces the external address for every transfer. Each request chooses the external lane width (8, 16 or 32 bits) and the internal word width (16, 32, 48 or 64 bits). The number of transfers is the internal width divided by the lane width, rounded up.

Instruction fetches always return a 48-bit word. A fetch can be packed, using the same narrow transfers as a data read. It can also be unpacked: one transfer that reads the 32-bit bus and an auxiliary 16-bit input together. The unpacked form is used only when the chip-level 2-bit pack-mode selector holds 01.

Every transfer waits for an external acknowledge. The block accepts a new request only while it is idle. Completion is signalled by a single-cycle pulse.

Top module: `xbus_packer`

## Requirements
- R1: After reset, `busy`, `bus_req` and `done` are all 0.
- R2: Lane width code `req_xw` is 00=8, 01=16, 10 or 11=32 bits. Word width code `req_iw` is 00=16, 01=32, 10=48, 11=64 bits. A request makes exactly ceil(word/lane) external transfers, and each transfer ends with one `bus_ack`.
- R3: The first transfer uses `req_addr` as its address. Each following transfer uses the previous address plus one.
- R4: Read data is assembled least-significant first: transfer k supplies word bits [k*lane +: lane]. Only the low 8 or 16 bus bits are used in the narrow modes. Word bits above the selected width read as 0.
- R5: A 48-bit word with 32-bit lanes takes bits 31:0 from the first transfer and bits 47:32 from the low 16 bits of the second transfer.
- R6: On a write, transfer k drives word bits [k*lane +: lane] on the low lanes of `bus_wdata`, with `bus_we`=1. All bus bits above the lane, and all word bits above the selected width, are driven as 0.
- R7: While `bus_req` is high and `bus_ack` is low, `bus_req` stays high and `bus_addr` holds its value.
- R8: `done` is high for exactly one cycle: the cycle after the clock edge that samples the last acknowledge. `busy` and `bus_req` are low in that cycle. `rdata` is valid in that cycle.
- R9: A `req_valid` that arrives while `busy` is high is ignored. The transfer in progress keeps its addresses and beat count, and no extra transfer follows.
- R10: `req_ifetch`=1 forces a 48-bit read, whatever `req_iw` and `req_write` say. When `pack_mode`=01 it is one transfer, and `rdata` = {`bus_rdata_hi`, `bus_rdata`}.
- R11: When `pack_mode` is not 01, an instruction fetch is packed according to `req_xw`, and `bus_rdata_hi` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pack_mode | input | 2 | Chip pack-mode selector; 01 enables the auxiliary 16 lines |
| req_valid | input | 1 | Internal request strobe, taken when not busy |
| req_addr | input | 24 | First external word address |
| req_iw | input | 2 | Internal word width code |
| req_xw | input | 2 | External lane width code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ifetch | input | 1 | Instruction fetch (48-bit read) |
| req_wdata | input | 64 | Internal word to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 64 | Assembled read word |
| bus_req | output | 1 | External transfer active |
| bus_we | output | 1 | External write enable |
| bus_addr | output | 24 | External word address |
| bus_wdata | output | 32 | External write data |
| bus_rdata | input | 32 | External read data |
| bus_rdata_hi | input | 16 | Auxiliary read lines for unpacked fetch |
| bus_ack | input | 1 | External acknowledge for the current transfer |

## Verification
A request taken at one clock edge raises `bus_req` at the next falling edge. Each acknowledge driven at a falling edge is sampled at the following rising edge. After the last acknowledge, `done` and the final `rdata` appear at the falling edge that comes next. The bench drives the acknowledge on falling edges, with a wait of zero to two cycles, and records the address and write data at each acknowledged transfer. It requires `done` on exactly the falling edge after the last acknowledge, and checks the recorded transfers against values it computes from the address pattern and the width codes.

// File: rtl/xpk_pkg.sv
package xpk_pkg;
  localparam logic [1:0] WIDE_PACK_SEL = 2'b01;
  localparam logic [1:0] IW_CODE_48    = 2'b10;

  function automatic int lane_bits(input logic [1:0] xw);
    case (xw)
      2'b00:   return 8;
      2'b01:   return 16;
      default: return 32;
    endcase
  endfunction

  function automatic int word_bits(input logic [1:0] iw);
    return 16 * (int'(iw) + 1);
  endfunction

  function automatic logic [3:0] beat_total(input logic [1:0] iw, input logic [1:0] xw,
                                            input logic wide);
    int lb;
    lb = lane_bits(xw);
    if (wide) return 4'd1;
    return 4'((word_bits(iw) + lb - 1) / lb);
  endfunction

  function automatic logic [31:0] lane_mask(input logic [1:0] xw);
    return 32'hFFFF_FFFF >> (32 - lane_bits(xw));
  endfunction

  function automatic logic [63:0] word_mask(input logic [1:0] iw);
    return 64'hFFFF_FFFF_FFFF_FFFF >> (64 - word_bits(iw));
  endfunction

  function automatic int beat_shift(input logic [3:0] beat, input logic [1:0] xw);
    return int'(beat) * lane_bits(xw);
  endfunction
endpackage

// File: rtl/xpk_ctrl.sv
module xpk_ctrl
  import xpk_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pack_mode,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_iw,
  input  logic [1:0]        req_xw,
  input  logic              req_write,
  input  logic              req_ifetch,
  input  logic              bus_ack,
  output logic              busy,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BEAT_W-1:0] beat_idx,
  output logic [1:0]        cur_xw,
  output logic [1:0]        cur_iw,
  output logic              cur_wide,
  output logic              start,
  output logic              beat_fire,
  output logic              done
);
  logic              busy_q, we_q, wide_q, done_q;
  logic [BEAT_W-1:0] beat_q, beats_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        xw_q, iw_q;
  logic              wide_sel, last_beat;

  assign wide_sel  = req_ifetch && (pack_mode == WIDE_PACK_SEL);
  assign start     = req_valid && !busy_q;
  assign beat_fire = busy_q && bus_ack;
  assign last_beat = (beat_q == beats_q - BEAT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      wide_q  <= 1'b0;
      done_q  <= 1'b0;
      beat_q  <= '0;
      beats_q <= '0;
      addr_q  <= '0;
      xw_q    <= 2'b00;
      iw_q    <= 2'b00;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q  <= 1'b1;
        addr_q  <= req_addr;
        beat_q  <= '0;
        xw_q    <= req_xw;
        iw_q    <= req_ifetch ? IW_CODE_48 : req_iw;
        we_q    <= req_ifetch ? 1'b0 : req_write;
        wide_q  <= wide_sel;
        beats_q <= BEAT_W'(beat_total(req_ifetch ? IW_CODE_48 : req_iw, req_xw, wide_sel));
      end else if (beat_fire) begin
        if (last_beat) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          beat_q <= beat_q + BEAT_W'(1);
          addr_q <= addr_q + ADDR_W'(1);
        end
      end
    end
  end

  assign busy     = busy_q;
  assign bus_req  = busy_q;
  assign bus_we   = busy_q && we_q;
  assign bus_addr = addr_q;
  assign beat_idx = beat_q;
  assign cur_xw   = xw_q;
  assign cur_iw   = iw_q;
  assign cur_wide = wide_q;
  assign done     = done_q;

  AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr)); // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !last_beat |=> bus_addr == $past(bus_addr) + ADDR_W'(1)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !bus_req); // R8
  AST_BEAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> beat_q < beats_q); // R2
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    busy && req_valid && !beat_fire |=> $stable(beats_q) && $stable(bus_addr)); // R9
endmodule

// File: rtl/xpk_unpack.sv
module xpk_unpack
  import xpk_pkg::*;
#(
  parameter int XD_W   = 32,
  parameter int XHI_W  = 16,
  parameter int IW_W   = 64,
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              beat_fire,
  input  logic [BEAT_W-1:0] beat_idx,
  input  logic [1:0]        xw,
  input  logic [1:0]        iw,
  input  logic              wide,
  input  logic [XD_W-1:0]   bus_rdata,
  input  logic [XHI_W-1:0]  bus_rdata_hi,
  output logic [IW_W-1:0]   word
);
  localparam int WIDE_W = XD_W + XHI_W;

  logic [IW_W-1:0] acc_q, lane_ext, wide_ext;

  assign lane_ext = IW_W'(bus_rdata & XD_W'(lane_mask(xw)));
  assign wide_ext = IW_W'({bus_rdata_hi, bus_rdata});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (start) begin
      acc_q <= '0;
    end else if (beat_fire) begin
      if (wide) acc_q <= wide_ext;
      else      acc_q <= acc_q | (lane_ext << beat_shift(4'(beat_idx), xw));
    end
  end

  assign word = acc_q & IW_W'(word_mask(iw));

  AST_WIDE_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && wide |-> beat_idx == '0); // R10
  AST_WIDE_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && wide |=> acc_q[IW_W-1:WIDE_W] == '0); // R10
endmodule

// File: rtl/xpk_split.sv
module xpk_split
  import xpk_pkg::*;
#(
  parameter int XD_W   = 32,
  parameter int IW_W   = 64,
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IW_W-1:0]   req_wdata,
  input  logic              we,
  input  logic [BEAT_W-1:0] beat_idx,
  input  logic [1:0]        xw,
  input  logic [1:0]        iw,
  output logic [XD_W-1:0]   bus_wdata
);
  logic [IW_W-1:0] word_q, shifted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= '0;
    else if (start) word_q <= req_wdata;
  end

  assign shifted   = (word_q & IW_W'(word_mask(iw))) >> beat_shift(4'(beat_idx), xw);
  assign bus_wdata = we ? (shifted[XD_W-1:0] & XD_W'(lane_mask(xw))) : '0;
endmodule

// File: rtl/xbus_packer.sv
module xbus_packer
  import xpk_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int XD_W   = 32,
  parameter int XHI_W  = 16,
  parameter int IW_W   = 64,
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pack_mode,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_iw,
  input  logic [1:0]        req_xw,
  input  logic              req_write,
  input  logic              req_ifetch,
  input  logic [IW_W-1:0]   req_wdata,
  output logic              busy,
  output logic              done,
  output logic [IW_W-1:0]   rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [XD_W-1:0]   bus_wdata,
  input  logic [XD_W-1:0]   bus_rdata,
  input  logic [XHI_W-1:0]  bus_rdata_hi,
  input  logic              bus_ack
);
  logic [BEAT_W-1:0] beat_idx;
  logic [1:0]        cur_xw, cur_iw;
  logic              cur_wide, start, beat_fire;

  xpk_ctrl #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pack_mode(pack_mode),
    .req_valid(req_valid), .req_addr(req_addr), .req_iw(req_iw), .req_xw(req_xw),
    .req_write(req_write), .req_ifetch(req_ifetch), .bus_ack(bus_ack),
    .busy(busy), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .beat_idx(beat_idx), .cur_xw(cur_xw), .cur_iw(cur_iw), .cur_wide(cur_wide),
    .start(start), .beat_fire(beat_fire), .done(done)
  );

  xpk_unpack #(.XD_W(XD_W), .XHI_W(XHI_W), .IW_W(IW_W), .BEAT_W(BEAT_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .start(start), .beat_fire(beat_fire),
    .beat_idx(beat_idx), .xw(cur_xw), .iw(cur_iw), .wide(cur_wide),
    .bus_rdata(bus_rdata), .bus_rdata_hi(bus_rdata_hi), .word(rdata)
  );

  xpk_split #(.XD_W(XD_W), .IW_W(IW_W), .BEAT_W(BEAT_W)) u_split (
    .clk(clk), .rst_n(rst_n), .start(start), .req_wdata(req_wdata),
    .we(bus_we), .beat_idx(beat_idx), .xw(cur_xw), .iw(cur_iw),
    .bus_wdata(bus_wdata)
  );

  AST_LANE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we |-> (bus_wdata & ~XD_W'(lane_mask(cur_xw))) == '0); // R6
  AST_FETCH_READS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && cur_wide |-> !bus_we); // R10
  AST_REQ_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy && !done); // R8
endmodule

// File: tb/tb_xbus_packer.sv
module tb_xbus_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  pack_mode = 2'b00;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_iw = '0, req_xw = '0;
  logic        req_write = 1'b0, req_ifetch = 1'b0;
  logic [63:0] req_wdata = '0;
  logic        busy, done, bus_req, bus_we;
  logic [63:0] rdata;
  logic [23:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [15:0] bus_rdata_hi;
  logic        bus_ack = 1'b0;

  int checks = 0, errors = 0;
  logic [23:0] log_addr [8];
  logic [31:0] log_wd   [8];
  logic        log_we   [8];
  int          n_beats;
  logic [63:0] got_rdata;
  int          done_gap;

  always #2 clk = ~clk;

  xbus_packer dut (
    .clk(clk), .rst_n(rst_n), .pack_mode(pack_mode), .req_valid(req_valid),
    .req_addr(req_addr), .req_iw(req_iw), .req_xw(req_xw), .req_write(req_write),
    .req_ifetch(req_ifetch), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdata_hi(bus_rdata_hi),
    .bus_ack(bus_ack)
  );

  function automatic logic [31:0] pat(input logic [23:0] a);
    return ({8'd0, a} * 32'h0103_0507) ^ 32'h5A5A_C3C3;
  endfunction
  function automatic logic [15:0] pat_hi(input logic [23:0] a);
    return a[15:0] ^ 16'hBEEF;
  endfunction
  assign bus_rdata    = pat(bus_addr);
  assign bus_rdata_hi = pat_hi(bus_addr);

  function automatic int lw(input int code);
    return (code == 0) ? 8 : (code == 1) ? 16 : 32;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one request; records transfers. hold_req keeps req_valid high while busy.
  task automatic run_xfer(input logic [23:0] a, input int xw, input int iw, input bit we,
                          input bit ifetch, input logic [1:0] pm, input logic [63:0] wd,
                          input bit hold_req, input int seed);
    int waitleft, cyc, last_ack;
    bit waiting;
    logic [23:0] prev_addr;
    @(negedge clk);
    pack_mode = pm; req_addr = a; req_xw = 2'(xw); req_iw = 2'(iw);
    req_write = we; req_ifetch = ifetch; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    if (hold_req) req_addr = a + 24'h100;
    else req_valid = 1'b0;
    n_beats = 0; cyc = 0; last_ack = -10; waiting = 0; done_gap = -1;
    waitleft = seed % 3; prev_addr = '0;
    forever begin
      if (done) begin
        req_valid = 1'b0;
        done_gap = cyc - last_ack;
        got_rdata = rdata;
        chk(!busy && !bus_req, "R8 idle at done", {62'd0, busy, bus_req}, 64'd0);
        break;
      end
      if (bus_req) begin
        if (waiting) chk(bus_addr == prev_addr, "R7 addr hold", 64'(bus_addr), 64'(prev_addr));
        if (waitleft == 0) begin
          bus_ack = 1'b1;
          if (n_beats < 8) begin
            log_addr[n_beats] = bus_addr; log_wd[n_beats] = bus_wdata; log_we[n_beats] = bus_we;
          end
          n_beats++; last_ack = cyc; waiting = 0;
          waitleft = (seed + n_beats) % 3;
        end else begin
          bus_ack = 1'b0; waitleft--; waiting = 1;
        end
        prev_addr = bus_addr;
      end else begin
        bus_ack = 1'b0;
      end
      @(negedge clk);
      cyc++;
      if (cyc > 200) begin
        chk(1'b0, "R8 done never seen", 64'(cyc), 64'd0);
        break;
      end
    end
    bus_ack = 1'b0;
  endtask

  task automatic check_xfer(input logic [23:0] a, input int xw, input int iw, input bit we,
                            input bit wide, input logic [63:0] wd, input string tag);
    int xb, ib, nb;
    logic [63:0] exp, imask;
    xb = lw(xw); ib = 16 * (iw + 1);
    nb = wide ? 1 : (ib + xb - 1) / xb;
    imask = {64{1'b1}} >> (64 - ib);
    chk(n_beats == nb, {"R2 beat count ", tag}, 64'(n_beats), 64'(nb));
    chk(done_gap == 1, {"R8 done timing ", tag}, 64'(done_gap), 64'd1);
    for (int k = 0; k < nb && k < 8; k++) begin
      chk(log_addr[k] == a + 24'(k), {"R3 beat addr ", tag}, 64'(log_addr[k]), 64'(a + 24'(k)));
      if (we) begin
        exp = ((wd & imask) >> (k * xb)) & ({64{1'b1}} >> (64 - xb));
        chk(log_we[k] && log_wd[k] == exp[31:0], {"R6 write lanes ", tag},
            64'(log_wd[k]), exp);
      end else begin
        chk(!log_we[k], {"R10 read only ", tag}, 64'(log_we[k]), 64'd0);
      end
    end
    if (!we) begin
      exp = '0;
      if (wide) exp = {16'd0, pat_hi(a), pat(a)};
      else
        for (int k = 0; k < nb; k++)
          exp = exp | ((64'(pat(a + 24'(k))) & ({64{1'b1}} >> (64 - xb))) << (k * xb));
      exp = exp & imask;
      chk(got_rdata == exp, {"R4 R5 read word ", tag}, got_rdata, exp);
    end
  endtask

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk);
    chk(1'b0, "watchdog", 64'd0, 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] wv;
    int seed;
    repeat (3) @(negedge clk);
    chk(!busy && !bus_req && !done, "R1 reset state", {61'd0, busy, bus_req, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !bus_req && !done, "R1 after release", {61'd0, busy, bus_req, done}, 64'd0);
    seed = 0;
    // R2 R3 R4 R5 R6: full sweep of lane width, word width and direction
    for (int xw = 0; xw < 3; xw++)
      for (int iw = 0; iw < 4; iw++)
        for (int we = 0; we < 2; we++) begin
          logic [23:0] a;
          a = 24'h0F_FFFC + 24'(seed * 37);
          wv = 64'hFEDC_BA98_7654_3210 ^ {32'(seed), 32'(seed * 7919)};
          run_xfer(a, xw, iw, 1'(we), 1'b0, 2'b00, wv, 1'b0, seed);
          check_xfer(a, xw, iw, 1'(we), 1'b0, wv, "sweep");
          seed++;
        end
    // R10: unpacked fetch with pack_mode 01, write and width fields ignored
    run_xfer(24'h12_3456, 0, 0, 1'b1, 1'b1, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1);
    check_xfer(24'h12_3456, 0, 2, 1'b0, 1'b1, 64'd0, "R10 wide fetch");
    // R11: packed fetches when pack_mode is not 01, hi lines ignored
    for (int xw = 0; xw < 3; xw++) begin
      run_xfer(24'h00_0200 + 24'(xw * 16), xw, 3, 1'b0, 1'b1, 2'b10, 64'd0, 1'b0, xw);
      check_xfer(24'h00_0200 + 24'(xw * 16), xw, 2, 1'b0, 1'b0, 64'd0, "R11 packed fetch");
    end
    // R9: request held high during a transfer is ignored
    run_xfer(24'h00_4000, 1, 3, 1'b0, 1'b0, 2'b00, 64'd0, 1'b1, 2);
    check_xfer(24'h00_4000, 1, 3, 1'b0, 1'b0, 64'd0, "R9 busy hold");
    @(negedge clk);
    chk(!busy && !bus_req, "R9 no extra transfer", {62'd0, busy, bus_req}, 64'd0);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule